// File: doc/BRIEF.md
# Two-Phase Polyphase Lane Filter

This block filters a stream of 32-bit words, each of which holds four separate 8-bit unsigned samples called lanes. For every accepted word, each lane multiplies its sample by four coefficients of its own. It keeps a fixed 8-bit window of each product and feeds the four results into one of two transposed delay chains. The chain is chosen by a phase bit that flips on every accepted word. Even words use the forward chain, and odd words use a second chain that takes the coefficients in reverse order. Each lane produces one 8-bit result per word, and the four results are packed back into one 32-bit output word.

Words enter and leave through valid/ready handshakes. The input carries an end-of-stream flag that travels with its word to the output. A single output register decouples the two sides. The input is ready whenever that register is empty or is being emptied in the same cycle, so the filter takes one word per cycle while the consumer keeps up. Coefficients are held in a small register bank written through a one-cycle write port. The multiplier can be a plain product or a shift-and-add sum, selected by a parameter.

Top module: `poly_fir_lanes`

## Requirements
- R1: Lane k occupies bits [8k+7:8k] of both the input word and the output word. Each lane uses only its own coefficients and its own chain state, so a lane's result does not depend on the other lanes' samples.
- R2: Each 8-bit sample is multiplied by a 12-bit unsigned coefficient. Bits [19:12] of the 20-bit product are the scaled value s1..s4 used by the chains, where s1..s4 belong to taps 1..4.
- R3: On an even-phase word, a lane outputs a1 + s1. Its forward chain then becomes a1 = a2 + s2, a2 = a3 + s3 and a3 = s4. All sums are 8-bit and wrap modulo 256.
- R4: On an odd-phase word, a lane outputs b1 + s4. Its reverse chain then becomes b1 = b2 + s3, b2 = b3 + s2 and b3 = s1. Only the chain of the current phase changes.
- R5: The phase is even for the first word after reset and inverts after each accepted word. It holds while no word is accepted.
- R6: Each accepted input word yields exactly one output word, in order. That word is valid from the clock edge that accepts the input. It carries the end-of-stream flag of the word it came from.
- R7: While the output is valid and not taken, its data and flag stay unchanged and the input is not ready.
- R8: Synchronous reset clears all chain registers and all coefficients to zero, sets the phase to even and leaves the output empty.
- R9: A coefficient write at cfg_addr = 4*lane + tap (tap 0..3 for taps 1..4) is used by words accepted at later clock edges. A word accepted at the same edge as the write still sees the old value.
- R10: While out_ready is high, in_ready is high, so one word can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient index, 4*lane + tap |
| cfg_data | input | 12 | Coefficient value, unsigned |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Filter can take a word this cycle |
| in_data | input | 32 | Four packed 8-bit samples |
| in_last | input | 1 | End-of-stream flag of the input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Four packed 8-bit filter results |
| out_last | output | 1 | End-of-stream flag carried with the result |

## Verification
An output word is due at the clock edge that accepts its input, so it appears one cycle later with no further stage. A coefficient write takes effect one edge after its strobe. The bench changes inputs just after each falling edge and evaluates both handshakes one nanosecond later, before the next rising edge. At that point it decides which transfers that edge will make, compares any word being taken against the head of a queue filled by its own two-chain model, and only then advances the model and applies any pending coefficient write. This keeps same-edge writes on the old value. When the output is stalled, the bench records it and checks that the word is unchanged one cycle later.

// File: rtl/poly_fir_pkg.sv
package poly_fir_pkg;

   // Tap count of the per-lane polyphase structure
   localparam int TAPS = 4;

   // Which delay chain the current word updates
   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } phase_e;

   // Multiplier implementation selector
   localparam int MUL_DIRECT    = 0;
   localparam int MUL_SHIFT_ADD = 1;

endpackage

// File: rtl/poly_coef_bank.sv
module poly_coef_bank
   import poly_fir_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int COEF_W = 12,
   parameter int ADDR_W = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [COEF_W-1:0]               wr_data,
   output logic [LANES*TAPS*COEF_W-1:0]    coef_flat
);

   localparam int NCOEF = LANES * TAPS;

   generate
      if (NCOEF > (1 << ADDR_W)) begin : g_bad_addr
         $error("poly_coef_bank: address too narrow for coefficient count");
      end
   endgenerate

   // One register per coefficient, index = lane*TAPS + tap
   for (genvar i = 0; i < NCOEF; i++) begin : g_entry
      logic [COEF_W-1:0] c_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            c_q <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
            c_q <= wr_data;
         end
      end
      assign coef_flat[i*COEF_W +: COEF_W] = c_q;
   end

endmodule

// File: rtl/poly_tap_slice.sv
module poly_tap_slice
   import poly_fir_pkg::*;
#(
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12,
   parameter int MUL_STYLE = MUL_DIRECT
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [COEF_W-1:0]   coef,
   output logic [SAMPLE_W-1:0] scaled
);

   localparam int PROD_W = SAMPLE_W + COEF_W;

   generate
      if (SLICE_LSB + SAMPLE_W > PROD_W) begin : g_bad_slice
         $error("poly_tap_slice: slice window exceeds product width");
      end
   endgenerate

   logic [PROD_W-1:0] prod;

   generate
      if (MUL_STYLE == MUL_SHIFT_ADD) begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int b = 0; b < COEF_W; b++) begin
               if (coef[b]) begin
                  prod = prod + (PROD_W'(sample) << b);
               end
            end
         end
      end else begin : g_direct
         assign prod = PROD_W'(sample) * PROD_W'(coef);
      end
   endgenerate

   // Fixed window of the product, starting at SLICE_LSB
   assign scaled = SAMPLE_W'(prod >> SLICE_LSB);

endmodule

// File: rtl/poly_lane.sv
module poly_lane
   import poly_fir_pkg::*;
#(
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12,
   parameter int MUL_STYLE = MUL_DIRECT
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     adv,
   input  phase_e                   phase,
   input  logic [SAMPLE_W-1:0]      sample,
   input  logic [TAPS*COEF_W-1:0]   coefs,
   output logic [SAMPLE_W-1:0]      y
);

   localparam int DEPTH = TAPS - 1;

   logic [SAMPLE_W-1:0] s [TAPS];
   logic [SAMPLE_W-1:0] ev_q [DEPTH];
   logic [SAMPLE_W-1:0] od_q [DEPTH];

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      poly_tap_slice #(
         .SAMPLE_W  (SAMPLE_W),
         .COEF_W    (COEF_W),
         .SLICE_LSB (SLICE_LSB),
         .MUL_STYLE (MUL_STYLE)
      ) u_slice (
         .sample (sample),
         .coef   (coefs[t*COEF_W +: COEF_W]),
         .scaled (s[t])
      );
   end

   // Forward chain uses taps in order, reverse chain mirrors them
   always_comb begin
      if (phase == PH_ODD) begin
         y = od_q[0] + s[TAPS-1];
      end else begin
         y = ev_q[0] + s[0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            ev_q[i] <= '0;
            od_q[i] <= '0;
         end
      end else if (adv) begin
         if (phase == PH_ODD) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
               od_q[i] <= od_q[i+1] + s[TAPS-2-i];
            end
            od_q[DEPTH-1] <= s[0];
         end else begin
            for (int i = 0; i < DEPTH - 1; i++) begin
               ev_q[i] <= ev_q[i+1] + s[i+1];
            end
            ev_q[DEPTH-1] <= s[TAPS-1];
         end
      end
   end

endmodule

// File: rtl/poly_out_stage.sv
module poly_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              din_last,
   input  logic              out_ready,
   output logic              space,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);

   assign space = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= din;
         out_last  <= din_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/poly_fir_lanes.sv
module poly_fir_lanes
   import poly_fir_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12,
   parameter int MUL_STYLE = MUL_DIRECT
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               cfg_we,
   input  logic [$clog2(LANES*TAPS)-1:0]      cfg_addr,
   input  logic [COEF_W-1:0]                  cfg_data,
   input  logic                               in_valid,
   output logic                               in_ready,
   input  logic [LANES*SAMPLE_W-1:0]          in_data,
   input  logic                               in_last,
   output logic                               out_valid,
   input  logic                               out_ready,
   output logic [LANES*SAMPLE_W-1:0]          out_data,
   output logic                               out_last
);

   localparam int DATA_W  = LANES * SAMPLE_W;
   localparam int ADDR_W  = $clog2(LANES * TAPS);
   localparam int LANE_CW = TAPS * COEF_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("poly_fir_lanes: LANES must be at least 1");
      end
      if (MUL_STYLE != MUL_DIRECT && MUL_STYLE != MUL_SHIFT_ADD) begin : g_bad_mul
         $error("poly_fir_lanes: unknown MUL_STYLE");
      end
   endgenerate

   logic                       accept;
   logic                       space;
   phase_e                     phase_q;
   logic [LANES*LANE_CW-1:0]   coef_flat;
   logic [DATA_W-1:0]          result;

   assign in_ready = space;
   assign accept   = in_valid && space;

   poly_coef_bank #(
      .LANES  (LANES),
      .COEF_W (COEF_W),
      .ADDR_W (ADDR_W)
   ) u_coefs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (cfg_we),
      .wr_addr   (cfg_addr),
      .wr_data   (cfg_data),
      .coef_flat (coef_flat)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      poly_lane #(
         .SAMPLE_W  (SAMPLE_W),
         .COEF_W    (COEF_W),
         .SLICE_LSB (SLICE_LSB),
         .MUL_STYLE (MUL_STYLE)
      ) u_lane (
         .clk    (clk),
         .rst    (rst),
         .adv    (accept),
         .phase  (phase_q),
         .sample (in_data[k*SAMPLE_W +: SAMPLE_W]),
         .coefs  (coef_flat[k*LANE_CW +: LANE_CW]),
         .y      (result[k*SAMPLE_W +: SAMPLE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_EVEN;
      end else if (accept) begin
         phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
      end
   end

   poly_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .load      (accept),
      .din       (result),
      .din_last  (in_last),
      .out_ready (out_ready),
      .space     (space),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last)
   );

endmodule

// File: rtl/poly_fir_lanes_chk.sv
module poly_fir_lanes_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_last,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              phase
);

   logic acc;
   assign acc = in_valid && in_ready;

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!out_valid && !phase)); // R8

   AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_valid); // R6

   AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      acc |=> (out_last == $past(in_last))); // R6

   AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!acc && out_valid && out_ready) |=> !out_valid); // R6

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready); // R7

   AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
      acc |=> (phase != $past(phase))); // R5

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !acc |=> $stable(phase)); // R5

   AST_FREE_FLOW: assert property (@(posedge clk) disable iff (rst)
      out_ready |-> in_ready); // R10

endmodule

bind poly_fir_lanes poly_fir_lanes_chk #(
   .DATA_W (LANES * SAMPLE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .phase     (phase_q)
);

// File: tb/tb_poly_fir_lanes.sv
`timescale 1ns/1ps
module tb_poly_fir_lanes;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [11:0] cfg_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        out_last;

   always #5 clk = ~clk;

   poly_fir_lanes dut (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_data  (cfg_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   int n_checks = 0;
   int n_fail   = 0;
   string cur_tag = "R3 R4 mixed traffic";

   // Reference state
   logic [7:0]  m_fwd  [4][3];
   logic [7:0]  m_rev  [4][3];
   logic [11:0] m_coef [4][4];
   bit          m_odd;
   logic [32:0] expq [$];

   bit          held = 0;
   bit          acc_prev = 0;
   bit          hold_armed = 0;
   logic [31:0] hold_data;
   logic        hold_last;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // R2: product bits [19:12]
   function automatic logic [7:0] scale(input logic [7:0] smp, input logic [11:0] c);
      logic [19:0] p;
      p = 20'(smp) * 20'(c);
      return p[19:12];
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 3; i++) begin
            m_fwd[k][i] = '0;
            m_rev[k][i] = '0;
         end
         for (int t = 0; t < 4; t++) m_coef[k][t] = '0;
      end
      m_odd = 0;
   endtask

   // R1 R3 R4 R5: one accepted word through the two-chain recurrence
   task automatic model_step(input logic [31:0] d, input logic l);
      logic [31:0] y;
      logic [7:0]  s [4];
      for (int k = 0; k < 4; k++) begin
         for (int t = 0; t < 4; t++) s[t] = scale(d[8*k +: 8], m_coef[k][t]);
         if (!m_odd) begin
            y[8*k +: 8] = m_fwd[k][0] + s[0];
            m_fwd[k][0] = m_fwd[k][1] + s[1];
            m_fwd[k][1] = m_fwd[k][2] + s[2];
            m_fwd[k][2] = s[3];
         end else begin
            y[8*k +: 8] = m_rev[k][0] + s[3];
            m_rev[k][0] = m_rev[k][1] + s[2];
            m_rev[k][1] = m_rev[k][2] + s[1];
            m_rev[k][2] = s[0];
         end
      end
      m_odd = !m_odd;
      expq.push_back({l, y});
   endtask

   // Evaluate the coming edge 1 ns after inputs settle, then wait for the next falling edge
   task automatic tick();
      bit in_fire;
      bit out_fire;
      logic [32:0] e;
      #1;
      if (rst) begin
         model_reset();
         expq.delete();
         held = 0;
         acc_prev = 0;
         hold_armed = 0;
      end else begin
         if (hold_armed)
            check(out_valid && out_data == hold_data && out_last == hold_last,
                  "R7 stalled word unchanged", {out_last, out_data}, {hold_last, hold_data});
         if (acc_prev) check(out_valid, "R6 output valid after accept", out_valid, 1);
         if (out_ready) check(in_ready, "R10 ready while consumer ready", in_ready, 1);
         if (out_valid && !out_ready) check(!in_ready, "R7 input blocked on stall", in_ready, 0);
         in_fire  = in_valid && in_ready;
         out_fire = out_valid && out_ready;
         if (out_fire) begin
            if (expq.size() == 0) begin
               check(0, "R6 unexpected output word", {out_last, out_data}, 0);
            end else begin
               e = expq.pop_front();
               check({out_last, out_data} == e, cur_tag, {out_last, out_data}, e);
            end
         end
         if (in_fire) model_step(in_data, in_last);
         if (cfg_we) m_coef[cfg_addr[3:2]][cfg_addr[1:0]] = cfg_data; // R9 after same-edge word
         hold_armed = out_valid && !out_ready;
         hold_data  = out_data;
         hold_last  = out_last;
         acc_prev   = in_fire;
         held       = in_valid && !in_fire;
      end
      @(negedge clk);
   endtask

   task automatic cfg_write(input int lane, input int tap, input logic [11:0] v);
      cfg_we   = 1'b1;
      cfg_addr = 4'(lane * 4 + tap);
      cfg_data = v;
      tick();
      cfg_we   = 1'b0;
   endtask

   task automatic send(input logic [31:0] d, input logic l);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = l;
      tick();
      while (held) tick();
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic drain();
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (4) tick();
      check(expq.size() == 0, "R6 every word delivered", expq.size(), 0);
   endtask

   task automatic random_traffic(input int n);
      for (int c = 0; c < n; c++) begin
         if (!held) begin
            in_valid = ($urandom_range(0, 9) < 7);
            in_data  = $urandom;
            in_last  = ($urandom_range(0, 9) == 0);
         end
         out_ready = ($urandom_range(0, 9) < 6);
         cfg_we    = ($urandom_range(0, 19) == 0);
         cfg_addr  = 4'($urandom_range(0, 15));
         cfg_data  = 12'($urandom);
         tick();
      end
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2468));
      model_reset();
      @(negedge clk);
      tick();
      tick();
      rst = 1'b0;
      #1;
      // R8: empty output after reset
      check(!out_valid, "R8 output empty after reset", out_valid, 0);
      check(in_ready, "R8 input ready after reset", in_ready, 1);
      @(negedge clk);

      // R8: coefficients zero after reset, so results are zero
      cur_tag = "R8 cleared coefficients give zero";
      out_ready = 1'b1;
      send(32'hFFFF_FFFF, 1'b0);
      send(32'h8040_2010, 1'b0);
      drain();

      // R1: only lane 2 tap 1 nonzero, full-scale samples
      cur_tag = "R1 lane isolation";
      cfg_write(2, 0, 12'hFFF);
      out_ready = 1'b0;
      send(32'hFFFF_FFFF, 1'b0);
      #1;
      check(out_data == 32'h00FE_0000, "R1 R2 lane 2 max slice", out_data, 32'h00FE_0000);
      @(negedge clk);
      drain();

      // R9: write at same edge as a word uses old value for that word
      cur_tag = "R9 same-edge coefficient write";
      in_valid = 1'b1; in_data = 32'h0000_00FF; in_last = 1'b0;
      out_ready = 1'b1;
      cfg_we = 1'b1; cfg_addr = 4'd0; cfg_data = 12'h800;
      tick();
      cfg_we = 1'b0;
      in_valid = 1'b0;
      drain();

      // R2 R3 R4: full random coefficients, alternating phases back to back
      for (int k = 0; k < 4; k++)
         for (int t = 0; t < 4; t++)
            cfg_write(k, t, 12'($urandom));
      cur_tag = "R10 R3 R4 back-to-back";
      out_ready = 1'b1;
      for (int i = 0; i < 8; i++) begin
         in_valid = 1'b1;
         in_data  = $urandom;
         in_last  = (i == 7);
         tick();
         check(!held, "R10 word taken every cycle", held, 0);
      end
      in_valid = 1'b0;
      drain();

      // R2 wrap: maximum coefficients and samples
      cur_tag = "R2 R3 R4 wrap at full scale";
      for (int k = 0; k < 4; k++)
         for (int t = 0; t < 4; t++)
            cfg_write(k, t, 12'hFFF);
      out_ready = 1'b1;
      repeat (6) send(32'hFFFF_FFFF, 1'b0);
      drain();

      // R7 R5 R6: random traffic with backpressure and coefficient changes
      cur_tag = "R5 R6 R7 random backpressure";
      random_traffic(700);
      drain();

      // R8: reset mid-stream, then resume
      cur_tag = "R8 restart after reset";
      rst = 1'b1;
      in_valid = 1'b0;
      tick();
      tick();
      rst = 1'b0;
      for (int k = 0; k < 4; k++)
         for (int t = 0; t < 4; t++)
            cfg_write(k, t, 12'($urandom));
      random_traffic(400);
      drain();

      summary();
      $finish;
   end

endmodule